// File: doc/BRIEF.md
# Limit-Match Interval Timer Slice

This block is a single timer slice behind a small word-addressed register port. In its normal (limit) mode a count register rises by 512 on every tick of an internal prescaler. When the next step would meet or pass a programmed limit, the count wraps to zero, a reached flag is set and a level interrupt is raised. The interrupt stays high until software reads the limit register. A limit of zero turns the slice into a free-running counter that wraps at 0x7FFFFE00 without ever flagging a match.

A mode bit turns the same slice into a 64-bit user counter. In that mode it raises no interrupt, software can load the count, and a run-control bit starts and stops it. The behaviour is built around a three-state controller. LIMIT is normal counting. USER_HALT is user mode with the counter stopped. USER_RUN is user mode with the counter advancing. Its transitions are:

- LIMIT to USER_HALT when the mode bit is written to 1.
- USER_HALT to USER_RUN when the run bit is written to 1.
- USER_RUN to USER_HALT when the run bit is written to 0.
- USER_HALT or USER_RUN back to LIMIT when the mode bit is written to 0. This transition stops a running counter first.

Top module: `lmt_timer`

## Requirements
- R1: After reset the limit, count, reached flag, interrupt and mode bit are all zero, the state is LIMIT and the run register reads 1.
- R2: One tick occurs every TICK_DIV clock cycles, counting from reset release. A tick adds 512 to the count, so count bits 8:0 are always zero.
- R3: In LIMIT with a nonzero limit, a tick whose count plus 512 is at least the limit loads a count of 0, sets the reached flag and sets irq, all in the same clock edge. A match is also reported when the same cycle carries a limit read.
- R4: In LIMIT with a limit of 0, the count wraps from 0x7FFFFE00 to 0 and neither the reached flag nor irq is ever set.
- R5: In LIMIT, a write to word 0 (byte address 0x00) loads the limit as the data AND 0x7FFFFE00 and clears the count, the reached flag and irq. A write to word 2 (0x08) loads the limit the same way but leaves the count running. When such a write coincides with a tick, that tick is compared against the old limit. A read of word 2 returns the limit with no side effect.
- R6: In LIMIT, a read of word 0 returns the reached flag in bit 31 and limit bits 30:0, and it clears both the reached flag and irq. A read of word 1 (0x04) returns the reached flag in bit 31 and count bits 30:0, and it clears nothing.
- R7: In LIMIT, a write to word 1 has no effect.
- R8: Word 4 (0x10) bit 0 is the mode bit and reads back as written. Changing it in either direction clears the count, the reached flag and irq. Entering user mode goes to USER_HALT. Leaving it goes to LIMIT, with the limit kept. Writing the current value again has no effect.
- R9: In user mode, word 0 reads and writes count bits 63:32. Word 1 reads and writes count bits 31:0, and bits 8:0 of the written data are forced to zero. Either write clears the reached flag. irq stays low for the whole time the slice is in user mode. Writes to word 2 are ignored.
- R10: Word 3 (0x0C) bit 0 reads 1 while the count advances, which is in LIMIT or in USER_RUN. In user mode, writing 1 starts the counter and writing 0 stops it, and repeating the current value has no effect. In LIMIT, writes to word 3 are ignored.
- R11: A running user counter is 64 bits wide, so a carry out of bit 31 reaches the upper word.
- R12: An access is ignored in each of these cases: the word index is 5 or above, address bits 1:0 are nonzero, or bus_be is not 4'hF. An ignored write changes nothing. An ignored read returns 0 and has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables, all four required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq | output | 1 | Level interrupt on limit match |

## Verification
The assertions take for granted that every input is synchronous to clk and that reset is held for at least one clock edge. They also assume that no strobe arrives in the same cycle as a write to another register, so that write priority never has to be resolved between two addresses. The bench drives every input on the falling edge and issues at most one access per cycle, with all strobes low between accesses. It uses a short tick divider so that limit matches, wraps and 64-bit carries happen within a few hundred cycles.

// File: rtl/lmt_pkg.sv
package lmt_pkg;

    typedef enum logic [1:0] {
        ST_LIMIT     = 2'd0,
        ST_USER_HALT = 2'd1,
        ST_USER_RUN  = 2'd2
    } lmt_state_e;

    localparam int CNT_W      = 64;
    localparam int WORD_W     = 32;
    localparam int STEP_SHIFT = 9;
    localparam int FLAG_BIT   = 31;

    localparam logic [WORD_W-1:0] CNT_MAX32  = 32'h7FFF_FE00;
    localparam logic [WORD_W-1:0] LIMIT_MASK = 32'h7FFF_FE00;
    localparam logic [CNT_W-1:0]  STEP       = CNT_W'(1) << STEP_SHIFT;

    localparam int IDX_LIMIT    = 0;
    localparam int IDX_COUNT    = 1;
    localparam int IDX_LIMIT_NR = 2;
    localparam int IDX_RUN      = 3;
    localparam int IDX_MODE     = 4;
    localparam int NUM_REGS     = 5;

endpackage

// File: rtl/lmt_prescale.sv
module lmt_prescale #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV > 1) begin : g_div
            logic [PW-1:0] ph_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ph_q <= '0;
                end else if (ph_q == PW'(TICK_DIV - 1)) begin
                    ph_q <= '0;
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end

            assign tick = (ph_q == PW'(TICK_DIV - 1));

            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_every
            assign tick = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/lmt_regif.sv
module lmt_regif
    import lmt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic              user_mode,
    input  logic              advancing,
    input  logic              reached,
    input  logic [WORD_W-1:0] limit,
    input  logic [CNT_W-1:0]  cnt,
    output logic              wr_lim,
    output logic              wr_cnt,
    output logic              wr_nr,
    output logic              wr_run,
    output logic              wr_mode,
    output logic              rd_lim,
    output logic [WORD_W-1:0] rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             acc_ok;

    assign idx    = bus_addr[ADDR_W-1:2];
    assign acc_ok = (bus_addr[1:0] == 2'b00) && (bus_be == 4'hF)
                    && (idx < IDX_W'(NUM_REGS));

    always_comb begin
        wr_lim  = 1'b0;
        wr_cnt  = 1'b0;
        wr_nr   = 1'b0;
        wr_run  = 1'b0;
        wr_mode = 1'b0;
        if (bus_wr && acc_ok) begin
            unique case (idx)
                IDX_W'(IDX_LIMIT):    wr_lim  = 1'b1;
                IDX_W'(IDX_COUNT):    wr_cnt  = 1'b1;
                IDX_W'(IDX_LIMIT_NR): wr_nr   = 1'b1;
                IDX_W'(IDX_RUN):      wr_run  = 1'b1;
                IDX_W'(IDX_MODE):     wr_mode = 1'b1;
                default:              ;
            endcase
        end
    end

    assign rd_lim = bus_rd && acc_ok && (idx == IDX_W'(IDX_LIMIT));

    always_comb begin
        rdata = '0;
        if (bus_rd && acc_ok) begin
            unique case (idx)
                IDX_W'(IDX_LIMIT):
                    rdata = user_mode ? cnt[CNT_W-1:WORD_W]
                                      : {reached, limit[FLAG_BIT-1:0]};
                IDX_W'(IDX_COUNT):
                    rdata = user_mode ? cnt[WORD_W-1:0]
                                      : {reached, cnt[FLAG_BIT-1:0]};
                IDX_W'(IDX_LIMIT_NR): rdata = limit;
                IDX_W'(IDX_RUN):      rdata = {{(WORD_W-1){1'b0}}, advancing};
                IDX_W'(IDX_MODE):     rdata = {{(WORD_W-1){1'b0}}, user_mode};
                default:              rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/lmt_mode_fsm.sv
module lmt_mode_fsm
    import lmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_run,
    input  logic       wr_mode,
    input  logic       data_bit,
    output lmt_state_e state,
    output logic       user_mode,
    output logic       advancing,
    output logic       mode_flip
);
    lmt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIMIT: begin
                if (wr_mode && data_bit) state_d = ST_USER_HALT;
            end
            ST_USER_HALT: begin
                if (wr_mode && !data_bit)     state_d = ST_LIMIT;
                else if (wr_run && data_bit)  state_d = ST_USER_RUN;
            end
            ST_USER_RUN: begin
                if (wr_mode && !data_bit)     state_d = ST_LIMIT;
                else if (wr_run && !data_bit) state_d = ST_USER_HALT;
            end
            default: state_d = ST_LIMIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LIMIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state     = state_q;
        user_mode = (state_q != ST_LIMIT);
        advancing = (state_q != ST_USER_HALT);
        mode_flip = wr_mode && (data_bit != user_mode);
    end

    assert_run_only_user_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIMIT && !wr_mode) |=> (state_q == ST_LIMIT));

endmodule

// File: rtl/lmt_counter.sv
module lmt_counter
    import lmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_mode,
    input  logic              advancing,
    input  logic              mode_flip,
    input  logic              wr_lim,
    input  logic              wr_cnt,
    input  logic              wr_nr,
    input  logic              rd_lim,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [WORD_W-1:0] limit,
    output logic              reached,
    output logic              irq
);
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] lim_q;
    logic              rch_q;
    logic              irq_q;

    logic [WORD_W:0]   lo_sum;
    logic              wrap;
    logic              hit;
    logic [CNT_W-1:0]  cnt_step;

    assign lo_sum = {1'b0, cnt_q[WORD_W-1:0]} + (WORD_W+1)'(STEP);

    always_comb begin
        if (lim_q != '0) wrap = (lo_sum >= {1'b0, lim_q});
        else             wrap = (cnt_q[WORD_W-1:0] >= CNT_MAX32);
        hit = tick && !user_mode && (lim_q != '0) && wrap;
        if (user_mode)   cnt_step = cnt_q + STEP;
        else if (wrap)   cnt_step = '0;
        else             cnt_step = {{(CNT_W-WORD_W-1){1'b0}}, lo_sum};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
            rch_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (mode_flip) begin
            cnt_q <= '0;
            rch_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (wr_lim && !user_mode) begin
            lim_q <= wdata & LIMIT_MASK;
            cnt_q <= '0;
            rch_q <= 1'b0;
            irq_q <= 1'b0;
        end else if (wr_lim && user_mode) begin
            cnt_q[CNT_W-1:WORD_W] <= wdata;
            rch_q <= 1'b0;
        end else if (wr_cnt && user_mode) begin
            cnt_q[WORD_W-1:0] <= {wdata[WORD_W-1:STEP_SHIFT], {STEP_SHIFT{1'b0}}};
            rch_q <= 1'b0;
        end else begin
            if (wr_nr && !user_mode) lim_q <= wdata & LIMIT_MASK;
            if (tick && advancing)   cnt_q <= cnt_step;
            if (hit) begin
                rch_q <= 1'b1;
                irq_q <= 1'b1;
            end else if (rd_lim && !user_mode) begin
                rch_q <= 1'b0;
                irq_q <= 1'b0;
            end
        end
    end

    assign cnt     = cnt_q;
    assign limit   = lim_q;
    assign reached = rch_q;
    assign irq     = irq_q;

    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[STEP_SHIFT-1:0] == '0);
    assert_irq_has_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> rch_q);
    assert_irq_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(tick));
    assert_norm_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |-> (cnt_q[CNT_W-1:FLAG_BIT] == '0));
    assert_no_irq_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |-> !irq_q);

endmodule

// File: rtl/lmt_timer.sv
module lmt_timer
    import lmt_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int TICK_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic             tick;
    lmt_state_e       state;
    logic             user_mode, advancing, mode_flip;
    logic             wr_lim, wr_cnt, wr_nr, wr_run, wr_mode, rd_lim;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] limit;
    logic             reached;

    lmt_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    lmt_regif #(.ADDR_W(ADDR_W)) u_regif (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .user_mode (user_mode),
        .advancing (advancing),
        .reached   (reached),
        .limit     (limit),
        .cnt       (cnt),
        .wr_lim    (wr_lim),
        .wr_cnt    (wr_cnt),
        .wr_nr     (wr_nr),
        .wr_run    (wr_run),
        .wr_mode   (wr_mode),
        .rd_lim    (rd_lim),
        .rdata     (bus_rdata)
    );

    lmt_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_run    (wr_run),
        .wr_mode   (wr_mode),
        .data_bit  (bus_wdata[0]),
        .state     (state),
        .user_mode (user_mode),
        .advancing (advancing),
        .mode_flip (mode_flip)
    );

    lmt_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .user_mode (user_mode),
        .advancing (advancing),
        .mode_flip (mode_flip),
        .wr_lim    (wr_lim),
        .wr_cnt    (wr_cnt),
        .wr_nr     (wr_nr),
        .rd_lim    (rd_lim),
        .wdata     (bus_wdata),
        .cnt       (cnt),
        .limit     (limit),
        .reached   (reached),
        .irq       (irq)
    );

    assert_halt_holds_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_USER_HALT && !(wr_lim || wr_cnt || wr_nr || wr_run || wr_mode))
        |=> $stable(cnt));

endmodule

// File: tb/lmt_timer_test.sv
module lmt_timer_test;
    localparam int CLK_P = 10;
    localparam int DIV   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    logic [63:0] m_cnt;
    logic [31:0] m_lim;
    bit          m_rch, m_irq, m_user, m_run;
    int          m_ph;

    lmt_timer #(.ADDR_W(5), .TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic bit acc_ok();
        return (bus_addr[1:0] == 2'b00) && (bus_be == 4'hF) && (bus_addr[4:2] < 3'd5);
    endfunction

    function automatic logic [31:0] exp_read();
        logic [31:0] r;
        r = 32'h0;
        if (bus_rd && acc_ok()) begin
            case (bus_addr[4:2])
                3'd0: r = m_user ? m_cnt[63:32] : {m_rch, m_lim[30:0]};
                3'd1: r = m_user ? m_cnt[31:0]  : {m_rch, m_cnt[30:0]};
                3'd2: r = m_lim;
                3'd3: r = {31'h0, (!m_user || m_run)};
                3'd4: r = {31'h0, m_user};
                default: r = 32'h0;
            endcase
        end
        return r;
    endfunction

    // reference update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_lim = 0; m_rch = 0; m_irq = 0; m_user = 0; m_run = 0; m_ph = 0;
        end else begin
            bit w, tk, adv, hit, pend_lim, pend_run;
            logic [31:0] new_lim;
            logic [2:0]  ix;
            w  = bus_wr && acc_ok();
            ix = bus_addr[4:2];
            tk = (m_ph == DIV - 1);
            m_ph = tk ? 0 : m_ph + 1;
            if (w && ix == 3'd4 && (bus_wdata[0] != m_user)) begin
                m_user = bus_wdata[0]; m_run = 0; m_cnt = 0; m_rch = 0; m_irq = 0;
            end else if (w && ix == 3'd0 && !m_user) begin
                m_lim = bus_wdata & 32'h7FFFFE00; m_cnt = 0; m_rch = 0; m_irq = 0;
            end else if (w && ix == 3'd0) begin
                m_cnt[63:32] = bus_wdata; m_rch = 0;
            end else if (w && ix == 3'd1 && m_user) begin
                m_cnt[31:0] = bus_wdata & 32'hFFFFFE00; m_rch = 0;
            end else begin
                pend_lim = w && ix == 3'd2 && !m_user;
                pend_run = w && ix == 3'd3 && m_user;
                new_lim  = bus_wdata & 32'h7FFFFE00;
                adv = !m_user || m_run;
                hit = 0;
                if (tk && adv) begin
                    if (m_user) m_cnt = m_cnt + 64'd512;
                    else if (m_lim != 0 && m_cnt + 64'd512 >= {32'h0, m_lim}) begin
                        m_cnt = 0; hit = 1;
                    end else if (m_lim == 0 && m_cnt >= 64'h7FFFFE00) m_cnt = 0;
                    else m_cnt = m_cnt + 64'd512;
                end
                if (hit) begin
                    m_rch = 1; m_irq = 1;
                end else if (bus_rd && acc_ok() && ix == 3'd0 && !m_user) begin
                    m_rch = 0; m_irq = 0;
                end
                if (pend_lim) m_lim = new_lim;
                if (pend_run) m_run = bus_wdata[0];
            end
        end
    end

    // compare a quarter period after the falling edge, on every clock
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL %s irq got %0b exp %0b", cur_req, irq, m_irq);
            end
            if (bus_rd) begin
                logic [31:0] e;
                e = exp_read();
                checks++;
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s read addr %h got %h exp %h", cur_req, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_wr = 0; bus_rd = 0; bus_be = 4'h0;
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_rd = 1; bus_wr = 0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_rd = 0; bus_be = 4'h0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        rd(5'h00); rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h10);
        cur_req = "R2";
        for (int k = 0; k < 6; k++) begin idle(3); rd(5'h04); end
        cur_req = "R5";
        wr(5'h00, 32'h0000_1000); rd(5'h00); rd(5'h04);
        cur_req = "R3";
        idle(40);
        cur_req = "R6";
        rd(5'h04); idle(5); rd(5'h00); idle(2); rd(5'h00);
        cur_req = "R5";
        wr(5'h00, 32'hFFFF_FFFF); rd(5'h08);
        wr(5'h00, 32'h0000_4000); idle(40); rd(5'h04);
        wr(5'h08, 32'h0000_1000); rd(5'h04); idle(10); rd(5'h04); rd(5'h00);
        cur_req = "R7";
        rd(5'h04); wr(5'h04, 32'h1234_0000); rd(5'h04);
        cur_req = "R10";
        wr(5'h0C, 32'h0); rd(5'h0C); idle(6); rd(5'h04);
        cur_req = "R4";
        wr(5'h08, 32'h0); rd(5'h00); idle(60); rd(5'h00); rd(5'h04);
        cur_req = "R8";
        wr(5'h10, 32'h1); rd(5'h10); rd(5'h00); rd(5'h04); rd(5'h0C);
        idle(10); rd(5'h04); wr(5'h10, 32'h1); rd(5'h10);
        cur_req = "R9";
        wr(5'h04, 32'h0000_0A55); wr(5'h00, 32'h0000_0007);
        rd(5'h00); rd(5'h04); wr(5'h08, 32'h0000_0200); rd(5'h08);
        cur_req = "R10";
        wr(5'h0C, 32'h1); rd(5'h0C); idle(12); rd(5'h04);
        wr(5'h0C, 32'h1); rd(5'h04); wr(5'h0C, 32'h0); rd(5'h0C);
        idle(10); rd(5'h04); idle(8); rd(5'h04);
        cur_req = "R11";
        wr(5'h04, 32'hFFFF_FC00); wr(5'h00, 32'h0000_0001);
        wr(5'h0C, 32'h1); idle(14); rd(5'h00); rd(5'h04);
        cur_req = "R8";
        wr(5'h10, 32'h0); rd(5'h10); rd(5'h04); rd(5'h0C);
        wr(5'h00, 32'h0000_0800); idle(20); rd(5'h04);
        cur_req = "R12";
        rd(5'h00, 4'h7); idle(2); rd(5'h14); wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h01, 32'h0000_0000); wr(5'h00, 32'h0000_0000, 4'h3);
        rd(5'h1C); rd(5'h08); rd(5'h02); idle(3);
        cur_req = "R6";
        rd(5'h00); idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule